// File: doc/BRIEF.md
# Single-Accumulator Multi-Cycle Processor

This block is a small processor with one accumulator. Its program and its operands sit together in a single 32-word by 8-bit memory, which it reaches through one synchronous port. The processor does not finish an instruction in one cycle. It moves each word through a chain of named registers: a program counter, an address register, a data register, an instruction register and the accumulator. Each transfer takes a cycle of its own, so the sequence of fetch, decode and execute can be seen at the memory port from cycle to cycle.

An instruction word carries a 3-bit operation in its upper bits and a 5-bit memory address in its lower bits. The instruction set covers loads, stores, addition, subtraction, bitwise AND, an unconditional jump, a jump taken on a zero accumulator, and a halt. A surrounding system fills the memory during reset and then releases reset. It watches the halted flag and the accumulator to see when the program has ended and what it produced.

Top module: `acc_cpu`

## Requirements
- R1: Instructions and operands share one 32-word address space and one memory port. A STORE into a word that is later fetched changes the instruction that runs there.
- R2: An instruction word holds the operation in bits [7:5] and the address in bits [4:0]. The operation codes are: 0 LOAD, 1 STORE, 2 ADD, 3 SUB, 4 AND, 5 JMP, 6 JZ, 7 HALT.
- R3: The fetch sequence runs in order and spends one cycle on each step:
  - The program counter is copied into the address register and incremented by one.
  - The processor waits one cycle for the memory, whose read data appears one clock after the address.
  - The word read from memory is latched into the data register.
  - The data register is copied into the instruction register.
  - One decode cycle follows.
- R4: JMP loads the address field into the program counter and returns to fetch without an execute phase, for 5 cycles in total. JZ does the same only when the accumulator is zero. Otherwise it falls through to the next word, also in 5 cycles.
- R5: LOAD, ADD, SUB and AND take 8 cycles in total:
  - The address field is placed in the address register.
  - The processor waits for the memory read.
  - The word is latched into the data register.
  - The accumulator is updated.
  - ADD and SUB wrap modulo 256, and no flags are kept.
- R6: STORE writes the accumulator to the addressed word, with the write enable high for exactly one cycle. It takes 6 cycles in total.
- R7: The program counter and the address register are 5 bits wide and wrap from 31 to 0.
- R8: HALT takes 5 cycles and then raises the halted flag. From then on, until the next reset:
  - the accumulator and the memory address are frozen;
  - no memory write occurs.
- R9: While reset is held, the accumulator and the memory address read zero, and write enable and halted are low. Execution after reset starts by fetching address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 5 | Memory address, driven from the address register |
| mem_wdata | output | 8 | Memory write data, driven from the data register |
| mem_we | output | 1 | Memory write enable, high for the single write cycle of a STORE |
| mem_rdata | input | 8 | Memory read data, valid one clock after the address |
| halted | output | 1 | High once a HALT has been decoded |
| acc_out | output | 8 | Current accumulator value |

## Verification
Several properties are checked on every cycle:
- The write enable never stays high for two cycles in a row, and while it is high the write data equals the accumulator.
- The accumulator changes only in the execute-update step.
- The program counter is one ahead of the fetch address during the fetch wait cycle.
- A decoded JMP lands the program counter on the address field.
- Once the halted flag rises, it stays high and the port is frozen.
- Reset clears the observable outputs.

Other behaviour can only be shown by the bench's scenarios:
- the arithmetic results over a sweep of operand pairs, including wrap in both directions;
- the exact cycle count of each instruction class;
- whether a conditional jump is taken or falls through;
- program counter wrap past address 31;
- a program that overwrites one of its own instructions before reaching it.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 8;
    localparam int OP_W      = DATA_W - ADDR_W;
    localparam int MEM_WORDS = 1 << ADDR_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_ADD   = 3'd2,
        OP_SUB   = 3'd3,
        OP_AND   = 3'd4,
        OP_JMP   = 3'd5,
        OP_JZ    = 3'd6,
        OP_HALT  = 3'd7
    } opcode_e;

    typedef struct packed {
        opcode_e op;
        addr_t   addr;
    } instr_t;

    typedef enum logic [3:0] {
        S_F_ADDR,
        S_F_WAIT,
        S_F_LATCH,
        S_F_IR,
        S_DECODE,
        S_X_WAIT,
        S_X_LATCH,
        S_X_ALU,
        S_X_WRITE,
        S_HALT
    } state_e;

    typedef struct packed {
        logic pc_to_mar;
        logic pc_inc;
        logic mdr_from_mem;
        logic cir_from_mdr;
        logic pc_from_ir;
        logic mar_from_ir;
        logic mdr_from_acc;
        logic acc_from_alu;
        logic mem_we;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '0;

    function automatic instr_t split_word(word_t w);
        return instr_t'(w);
    endfunction

    function automatic logic is_jump(opcode_e op);
        return (op == OP_JMP) || (op == OP_JZ);
    endfunction

endpackage

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  opcode_e op,
    input  logic    acc_zero,
    output state_e  st,
    output ctl_t    ctl
);

    state_e st_q;
    state_e st_d;

    always_comb begin
        st_d = st_q;
        ctl  = CTL_IDLE;
        case (st_q)
            S_F_ADDR: begin
                ctl.pc_to_mar = 1'b1;
                ctl.pc_inc    = 1'b1;
                st_d          = S_F_WAIT;
            end
            S_F_WAIT:  st_d = S_F_LATCH;
            S_F_LATCH: begin
                ctl.mdr_from_mem = 1'b1;
                st_d             = S_F_IR;
            end
            S_F_IR: begin
                ctl.cir_from_mdr = 1'b1;
                st_d             = S_DECODE;
            end
            S_DECODE: begin
                if (is_jump(op)) begin
                    ctl.pc_from_ir = (op == OP_JMP) || acc_zero;
                    st_d           = S_F_ADDR;
                end else if (op == OP_HALT) begin
                    st_d = S_HALT;
                end else if (op == OP_STORE) begin
                    ctl.mar_from_ir  = 1'b1;
                    ctl.mdr_from_acc = 1'b1;
                    st_d             = S_X_WRITE;
                end else begin
                    ctl.mar_from_ir = 1'b1;
                    st_d            = S_X_WAIT;
                end
            end
            S_X_WAIT:  st_d = S_X_LATCH;
            S_X_LATCH: begin
                ctl.mdr_from_mem = 1'b1;
                st_d             = S_X_ALU;
            end
            S_X_ALU: begin
                ctl.acc_from_alu = 1'b1;
                st_d             = S_F_ADDR;
            end
            S_X_WRITE: begin
                ctl.mem_we = 1'b1;
                st_d       = S_F_ADDR;
            end
            S_HALT:  st_d = S_HALT;
            default: st_d = S_F_ADDR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= S_F_ADDR;
        else     st_q <= st_d;
    end

    assign st = st_q;

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
(
    input  opcode_e op,
    input  word_t   acc,
    input  word_t   operand,
    output word_t   result
);

    always_comb begin
        case (op)
            OP_LOAD: result = operand;
            OP_ADD:  result = acc + operand;
            OP_SUB:  result = acc - operand;
            OP_AND:  result = acc & operand;
            default: result = acc;
        endcase
    end

endmodule

// File: rtl/acc_cpu_regs.sv
module acc_cpu_regs
    import acc_cpu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  ctl_t   ctl,
    input  word_t  mem_rdata,
    input  word_t  alu_res,
    output addr_t  pc,
    output addr_t  mar,
    output word_t  mdr,
    output instr_t cir,
    output word_t  acc
);

    addr_t  pc_q;
    addr_t  mar_q;
    word_t  mdr_q;
    instr_t cir_q;
    word_t  acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            mar_q <= '0;
            mdr_q <= '0;
            cir_q <= '0;
            acc_q <= '0;
        end else begin
            if (ctl.pc_inc)          pc_q <= pc_q + addr_t'(1);
            else if (ctl.pc_from_ir) pc_q <= cir_q.addr;

            if (ctl.pc_to_mar)        mar_q <= pc_q;
            else if (ctl.mar_from_ir) mar_q <= cir_q.addr;

            if (ctl.mdr_from_mem)      mdr_q <= mem_rdata;
            else if (ctl.mdr_from_acc) mdr_q <= acc_q;

            if (ctl.cir_from_mdr) cir_q <= split_word(mdr_q);

            if (ctl.acc_from_alu) acc_q <= alu_res;
        end
    end

    assign pc  = pc_q;
    assign mar = mar_q;
    assign mdr = mdr_q;
    assign cir = cir_q;
    assign acc = acc_q;

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              halted,
    output logic [DATA_W-1:0] acc_out
);

    state_e st;
    ctl_t   ctl;
    addr_t  pc_q;
    addr_t  mar_q;
    word_t  mdr_q;
    instr_t cir_q;
    word_t  acc_q;
    word_t  alu_res;

    acc_cpu_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .op       (cir_q.op),
        .acc_zero (acc_q == '0),
        .st       (st),
        .ctl      (ctl)
    );

    acc_cpu_alu u_alu (
        .op      (cir_q.op),
        .acc     (acc_q),
        .operand (mdr_q),
        .result  (alu_res)
    );

    acc_cpu_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .alu_res   (alu_res),
        .pc        (pc_q),
        .mar       (mar_q),
        .mdr       (mdr_q),
        .cir       (cir_q),
        .acc       (acc_q)
    );

    assign mem_addr  = mar_q;
    assign mem_wdata = mdr_q;
    assign mem_we    = ctl.mem_we;
    assign halted    = (st == S_HALT);
    assign acc_out   = acc_q;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
    import acc_cpu_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input addr_t  mem_addr,
    input word_t  mem_wdata,
    input logic   mem_we,
    input logic   halted,
    input word_t  acc_out,
    input state_e st,
    input addr_t  pc_q,
    input instr_t cir_q
);

    a_r6_we_single: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    a_r6_we_data: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_wdata == acc_out));

    a_r5_acc_update_only: assert property (@(posedge clk) disable iff (rst)
        (st != S_X_ALU) |=> $stable(acc_out));

    a_r3_pc_ahead: assert property (@(posedge clk) disable iff (rst)
        (st == S_F_WAIT) |-> (pc_q == addr_t'(mem_addr + addr_t'(1))));

    a_r4_jmp_target: assert property (@(posedge clk) disable iff (rst)
        (st == S_DECODE && cir_q.op == OP_JMP) |=> (pc_q == $past(cir_q.addr)));

    a_r8_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
        halted |=> ($stable(acc_out) && $stable(mem_addr) && !mem_we));

    a_r9_reset_clear: assert property (@(posedge clk)
        rst |=> (acc_out == '0 && mem_addr == '0 && !mem_we && !halted));

endmodule

bind acc_cpu acc_cpu_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .halted    (halted),
    .acc_out   (acc_out),
    .st        (st),
    .pc_q      (pc_q),
    .cir_q     (cir_q)
);

// File: tb/acc_cpu_bench.sv
module acc_cpu_bench;

    localparam int CLK_PERIOD = 10;
    localparam int RUN_LIMIT  = 400;

    localparam logic [2:0] C_LOAD = 3'd0, C_STORE = 3'd1, C_ADD = 3'd2, C_SUB = 3'd3,
                           C_AND = 3'd4, C_JMP = 3'd5, C_JZ = 3'd6, C_HALT = 3'd7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] mem_addr;
    logic [7:0] mem_wdata;
    logic       mem_we;
    logic [7:0] mem_rdata;
    logic       halted;
    logic [7:0] acc_out;

    logic [7:0] mem [32];
    logic [7:0] img [32];
    logic [4:0] trace [512];
    int         wecnt;
    int         total = 0;
    int         fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_cpu u_acc_cpu (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .halted    (halted),
        .acc_out   (acc_out)
    );

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 32; i++) mem[i] <= img[i];
        end else if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
        end
        mem_rdata <= mem[mem_addr];
    end

    function automatic logic [7:0] enc(logic [2:0] op, logic [4:0] a);
        return {op, a};
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_img();
        for (int i = 0; i < 32; i++) img[i] = enc(C_HALT, 5'd0);
    endtask

    task automatic run_prog(output int cyc);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst   = 1'b0;
        cyc   = 0;
        wecnt = 0;
        while (!halted && cyc < RUN_LIMIT) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            trace[cyc] = mem_addr;
            if (mem_we) wecnt++;
        end
        chk(halted == 1'b1, "R8 program reached halt", int'(halted), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        total++;
        $display("FAIL watchdog R8 actual=timeout expected=finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int cyc;
        logic [7:0] vals [8];
        logic [2:0] ops [3];
        logic [7:0] frozen_acc;
        logic [4:0] frozen_addr;

        vals = '{8'h00, 8'h01, 8'h02, 8'h7F, 8'h80, 8'hFE, 8'hFF, 8'h5A};
        ops  = '{C_ADD, C_SUB, C_AND};

        // R9: reset state
        clear_img();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(acc_out == 8'h00, "R9 acc in reset", acc_out, 0);
        chk(halted == 1'b0, "R9 halted in reset", halted, 0);
        chk(mem_we == 1'b0, "R9 we in reset", mem_we, 0);
        chk(mem_addr == 5'd0, "R9 addr in reset", mem_addr, 0);

        // R2 R5 R6: operand sweep over ADD/SUB/AND with LOAD and STORE
        foreach (ops[k]) begin
            foreach (vals[i]) begin
                foreach (vals[j]) begin
                    logic [7:0] expv;
                    case (ops[k])
                        C_ADD:   expv = vals[i] + vals[j];
                        C_SUB:   expv = vals[i] - vals[j];
                        default: expv = vals[i] & vals[j];
                    endcase
                    clear_img();
                    img[0]  = enc(C_LOAD, 5'd20);
                    img[1]  = enc(ops[k], 5'd21);
                    img[2]  = enc(C_STORE, 5'd22);
                    img[3]  = enc(C_HALT, 5'd0);
                    img[20] = vals[i];
                    img[21] = vals[j];
                    run_prog(cyc);
                    chk(acc_out == expv, "R5 alu result", acc_out, expv);
                    chk(mem[22] == expv, "R6 stored value", mem[22], expv);
                    chk(cyc == 27, "R5 R6 R8 cycle count", cyc, 27);
                    chk(wecnt == 1, "R6 single write cycle", wecnt, 1);
                end
            end
        end

        // R4 R3: unconditional jump skips over a HALT
        clear_img();
        img[0]  = enc(C_JMP, 5'd5);
        img[1]  = enc(C_HALT, 5'd0);
        img[5]  = enc(C_LOAD, 5'd20);
        img[6]  = enc(C_HALT, 5'd0);
        img[20] = 8'h3C;
        run_prog(cyc);
        chk(acc_out == 8'h3C, "R4 jmp target executed", acc_out, 8'h3C);
        chk(cyc == 18, "R4 jmp cycle count", cyc, 18);
        chk(trace[1] == 5'd0, "R3 R9 first fetch address", trace[1], 0);
        chk(trace[6] == 5'd5, "R3 R4 fetch after jmp", trace[6], 5);
        chk(wecnt == 0, "R4 no write", wecnt, 0);

        // R4: JZ taken when accumulator is zero
        clear_img();
        img[0]  = enc(C_LOAD, 5'd20);
        img[1]  = enc(C_JZ, 5'd4);
        img[2]  = enc(C_LOAD, 5'd21);
        img[3]  = enc(C_HALT, 5'd0);
        img[4]  = enc(C_LOAD, 5'd22);
        img[5]  = enc(C_HALT, 5'd0);
        img[20] = 8'h00;
        img[21] = 8'h11;
        img[22] = 8'h22;
        run_prog(cyc);
        chk(acc_out == 8'h22, "R4 jz taken", acc_out, 8'h22);
        chk(cyc == 26, "R4 jz taken cycles", cyc, 26);

        // R4: JZ falls through when accumulator is nonzero
        img[20] = 8'h09;
        run_prog(cyc);
        chk(acc_out == 8'h11, "R4 jz not taken", acc_out, 8'h11);
        chk(cyc == 26, "R4 jz not taken cycles", cyc, 26);

        // R7: program counter wraps from 31 to 0
        clear_img();
        img[0]  = enc(C_JZ, 5'd31);
        img[1]  = enc(C_HALT, 5'd0);
        img[31] = enc(C_LOAD, 5'd20);
        img[20] = 8'h55;
        run_prog(cyc);
        chk(acc_out == 8'h55, "R7 word 31 executed", acc_out, 8'h55);
        chk(trace[6] == 5'd31, "R7 fetch at 31", trace[6], 31);
        chk(trace[14] == 5'd0, "R7 wrap to 0", trace[14], 0);
        chk(cyc == 23, "R7 cycle count", cyc, 23);

        // R1: STORE overwrites a later instruction with HALT
        clear_img();
        img[0]  = enc(C_LOAD, 5'd20);
        img[1]  = enc(C_STORE, 5'd3);
        img[2]  = enc(C_LOAD, 5'd21);
        img[3]  = enc(C_LOAD, 5'd22);
        img[4]  = enc(C_HALT, 5'd0);
        img[20] = enc(C_HALT, 5'd0);
        img[21] = 8'h11;
        img[22] = 8'h77;
        run_prog(cyc);
        chk(acc_out == 8'h11, "R1 modified instruction ran", acc_out, 8'h11);
        chk(mem[3] == 8'hE0, "R1 instruction word overwritten", mem[3], 8'hE0);
        chk(cyc == 27, "R1 cycle count", cyc, 27);

        // R8: frozen after halt
        frozen_acc  = acc_out;
        frozen_addr = mem_addr;
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            if (!halted || mem_we || acc_out != frozen_acc || mem_addr != frozen_addr) begin
                chk(1'b0, "R8 frozen after halt", acc_out, frozen_acc);
            end
        end
        chk(halted && acc_out == frozen_acc, "R8 still halted", acc_out, frozen_acc);

        // R8 R9: reset leaves the halted state
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(halted == 1'b0, "R8 R9 reset clears halted", halted, 0);
        chk(acc_out == 8'h00, "R9 reset clears acc", acc_out, 0);
        rst = 1'b0;

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule